// File: doc/BRIEF.md
# Vectored Dual-Class Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and presents them to a processor as two request outputs: one for the normal class and one for the fast class. Software configures each source through a 32-bit synchronous register port. Each source has an enable bit, a class bit, a software force bit and a 4-bit priority. Software can also switch a single enable on or off by writing its source number. The block does not need a read-modify-write for that.

Software reads two vector words to service requests. The normal vector word names the best normal source allowed through by a programmable mask level. The fast vector word names the lowest-numbered fast source. Both vectors are computed from the current register state and the input lines, so each change is reflected in the read that follows the write that caused it.

Top module: `vecIntCtl`

## Requirements
- R1: After reset, the control word (0x00) reads 0, the mask level (0x04) reads 0x1F, and every enable, class, force and priority word reads 0. The control word returns the last value written to it.
- R2: Writing n to 0x08 sets enable bit n, and writing n to 0x0C clears it, for n in 0..63. A written value of 64 or more leaves every enable bit unchanged.
- R3: A class bit of 1 (0x18 high, 0x1C low) puts its source in the fast class. A class bit of 0 puts it in the normal class.
- R4: A source is active when its input or its force bit is 1. Normal pending (0x58 high, 0x5C low) is active AND enabled AND class 0. Fast pending (0x60 high, 0x64 low) uses class 1 instead. The raw input lines read at 0x48 high and 0x4C low.
- R5: The normal vector word (0x40) holds, in bits [31:16], the number of the unmasked normal pending source with the largest priority. Between equal priorities the larger source number wins. Bits [31:16] read 0xFFFF when no such source exists, and bits [15:0] always read 0.
- R6: With a mask level L other than 0x1F, a normal pending source whose priority is at most L is hidden from the normal vector and from irqOut. L = 0x1F hides nothing. The normal pending words are not affected by L.
- R7: The fast vector word (0x44) holds the lowest-numbered fast pending source in bits [31:16], or 0xFFFF when none is pending. Bits [15:0] read 0.
- R8: irqOut is 1 exactly when some unmasked normal source is pending. fiqOut is 1 exactly when some fast source is pending.
- R9: The priority word for group g (sources 8g..8g+7) is at offset 0x20 + 4*(7-g). Source 8g+k uses bits [4k+3:4k] of that word.
- R10: Each per-source word pair has its high word (sources 32..63, bit n-32) at the lower offset and its low word (sources 0..31) at offset+4. The force pair is 0x50 high and 0x54 low, and the enable pair is 0x10 high and 0x14 low.
- R11: A register write changes the vector words on the next read, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busSel | input | 1 | Register access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 7 | Byte offset; accesses that are not word-aligned are ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current address (combinational) |
| srcIn | input | 64 | Level-sensitive interrupt lines |
| irqOut | output | 1 | Normal-class request |
| fiqOut | output | 1 | Fast-class request |

## Verification
The assertions assume three things about the inputs. The interrupt lines and the bus inputs are stable around each rising clock edge. At most one register access is made per cycle. Written source numbers may take any 32-bit value, including values outside the source range. The stimulus meets these conditions by changing the bus and the lines only on falling edges, issuing one access per cycle, and using out-of-range numbers on purpose to exercise the ignore rule.

// File: rtl/vecIntPkg.sv
package vecIntPkg;
  localparam int SrcN = 64;
  localparam int WordW = 32;
  localparam int PrioW = 4;
  localparam int LvlW = PrioW + 1;
  localparam int AddrW = 7;
  localparam int VecW = 16;
  localparam int SrcIdxW = $clog2(SrcN);
  localparam int WordsPerSet = SrcN / WordW;
  localparam int PrioPerWord = WordW / PrioW;
  localparam int PrioWords = SrcN / PrioPerWord;
  localparam int PrioIdxW = $clog2(PrioWords);
  localparam logic [VecW-1:0] VecNone = '1;

  typedef enum logic [3:0] {
    RdNone, RdCtl, RdLvl, RdEn, RdType, RdPrio, RdNVec,
    RdFVec, RdRaw, RdFrc, RdNPnd, RdFPnd
  } rdSelT;

  typedef struct packed {
    logic wrCtl;
    logic wrLvl;
    logic wrEnNum;
    logic wrDisNum;
    logic [WordsPerSet-1:0] wrEn;
    logic [WordsPerSet-1:0] wrType;
    logic [WordsPerSet-1:0] wrFrc;
    logic wrPrio;
    logic [PrioIdxW-1:0] prioIdx;
    logic hiWord;
    rdSelT rdSel;
  } strobeT;
endpackage

// File: rtl/vecIntDecode.sv
module vecIntDecode import vecIntPkg::*; (
  input  logic busSel,
  input  logic busWe,
  input  logic [AddrW-1:0] busAddr,
  output strobeT stb
);
  logic [AddrW-3:0] word;
  logic acc;

  assign word = busAddr[AddrW-1:2];
  assign acc = busSel && (busAddr[1:0] == 2'b00);

  always_comb begin
    stb = '0;
    stb.rdSel = RdNone;
    stb.hiWord = ~busAddr[2];
    stb.prioIdx = ~busAddr[PrioIdxW+1:2];
    if (acc) begin
      case (word)
        5'd0: begin stb.rdSel = RdCtl; stb.wrCtl = busWe; end
        5'd1: begin stb.rdSel = RdLvl; stb.wrLvl = busWe; end
        5'd2: stb.wrEnNum = busWe;
        5'd3: stb.wrDisNum = busWe;
        5'd4, 5'd5: begin stb.rdSel = RdEn; stb.wrEn[stb.hiWord] = busWe; end
        5'd6, 5'd7: begin stb.rdSel = RdType; stb.wrType[stb.hiWord] = busWe; end
        5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd14, 5'd15: begin
          stb.rdSel = RdPrio;
          stb.wrPrio = busWe;
        end
        5'd16: stb.rdSel = RdNVec;
        5'd17: stb.rdSel = RdFVec;
        5'd18, 5'd19: stb.rdSel = RdRaw;
        5'd20, 5'd21: begin stb.rdSel = RdFrc; stb.wrFrc[stb.hiWord] = busWe; end
        5'd22, 5'd23: stb.rdSel = RdNPnd;
        5'd24, 5'd25: stb.rdSel = RdFPnd;
        default: stb.rdSel = RdNone;
      endcase
    end
  end
endmodule

// File: rtl/vecIntPick.sv
module vecIntPick import vecIntPkg::*; #(
  parameter bit TieHigh = 1'b1
) (
  input  logic [SrcN-1:0] req,
  input  logic [SrcN*PrioW-1:0] rank,
  output logic [VecW-1:0] vec
);
  logic found;
  logic [SrcIdxW-1:0] best;
  logic [PrioW-1:0] bestRank;

  always_comb begin
    found = 1'b0;
    best = '0;
    bestRank = '0;
    for (int i = 0; i < SrcN; i++) begin
      if (req[i] && (!found ||
          (TieHigh ? (rank[i*PrioW +: PrioW] >= bestRank)
                   : (rank[i*PrioW +: PrioW] > bestRank)))) begin
        found = 1'b1;
        best = SrcIdxW'(i);
        bestRank = rank[i*PrioW +: PrioW];
      end
    end
    vec = found ? VecW'(best) : VecNone;
  end
endmodule

// File: rtl/vecIntRegs.sv
module vecIntRegs import vecIntPkg::*; (
  input  logic clk,
  input  logic rst,
  input  strobeT stb,
  input  logic [WordW-1:0] wdata,
  input  logic [SrcN-1:0] srcIn,
  output logic [WordW-1:0] rdata,
  output logic irqOut,
  output logic fiqOut
);
  logic [WordW-1:0] ctlReg;
  logic [LvlW-1:0] lvlReg;
  logic [SrcN-1:0] enReg, typeReg, frcReg;
  logic [SrcN*PrioW-1:0] prioFlat;
  logic [SrcN-1:0] active, normPend, fastPend, supp, normAct;
  logic [VecW-1:0] nVec, fVec;
  logic numOk;

  assign numOk = wdata < WordW'(SrcN);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctlReg <= '0;
      lvlReg <= '1;
      enReg <= '0;
      typeReg <= '0;
      frcReg <= '0;
      prioFlat <= '0;
    end else begin
      if (stb.wrCtl) ctlReg <= wdata;
      if (stb.wrLvl) lvlReg <= wdata[LvlW-1:0];
      if (stb.wrEnNum && numOk) enReg[wdata[SrcIdxW-1:0]] <= 1'b1;
      if (stb.wrDisNum && numOk) enReg[wdata[SrcIdxW-1:0]] <= 1'b0;
      for (int w = 0; w < WordsPerSet; w++) begin
        if (stb.wrEn[w]) enReg[w*WordW +: WordW] <= wdata;
        if (stb.wrType[w]) typeReg[w*WordW +: WordW] <= wdata;
        if (stb.wrFrc[w]) frcReg[w*WordW +: WordW] <= wdata;
      end
      if (stb.wrPrio) prioFlat[int'(stb.prioIdx)*WordW +: WordW] <= wdata;
    end
  end

  assign active = srcIn | frcReg;
  assign normPend = active & enReg & ~typeReg;
  assign fastPend = active & enReg & typeReg;

  for (genvar i = 0; i < SrcN; i++) begin : gSupp
    assign supp[i] = (lvlReg != '1) &&
                     ({1'b0, prioFlat[i*PrioW +: PrioW]} <= lvlReg);
  end

  assign normAct = normPend & ~supp;

  vecIntPick #(.TieHigh(1'b1)) u_normPick (
    .req(normAct), .rank(prioFlat), .vec(nVec)
  );
  vecIntPick #(.TieHigh(1'b0)) u_fastPick (
    .req(fastPend), .rank('0), .vec(fVec)
  );

  assign irqOut = |normAct;
  assign fiqOut = |fastPend;

  function automatic logic [WordW-1:0] half(input logic [SrcN-1:0] v, input logic hi);
    return v[int'(hi)*WordW +: WordW];
  endfunction

  always_comb begin
    case (stb.rdSel)
      RdCtl:  rdata = ctlReg;
      RdLvl:  rdata = WordW'(lvlReg);
      RdEn:   rdata = half(enReg, stb.hiWord);
      RdType: rdata = half(typeReg, stb.hiWord);
      RdPrio: rdata = prioFlat[int'(stb.prioIdx)*WordW +: WordW];
      RdNVec: rdata = {nVec, {(WordW-VecW){1'b0}}};
      RdFVec: rdata = {fVec, {(WordW-VecW){1'b0}}};
      RdRaw:  rdata = half(srcIn, stb.hiWord);
      RdFrc:  rdata = half(frcReg, stb.hiWord);
      RdNPnd: rdata = half(normPend, stb.hiWord);
      RdFPnd: rdata = half(fastPend, stb.hiWord);
      default: rdata = '0;
    endcase
  end

  assert_en_set_R2: assert property (@(posedge clk) disable iff (rst)
    (stb.wrEnNum && numOk) |=> enReg[$past(wdata[SrcIdxW-1:0])]);

  assert_dis_ignore_R2: assert property (@(posedge clk) disable iff (rst)
    (stb.wrDisNum && !numOk) |=> $stable(enReg));

  assert_irq_vec_R8: assert property (@(posedge clk) disable iff (rst)
    irqOut == (nVec != VecNone));

  assert_fiq_vec_R8: assert property (@(posedge clk) disable iff (rst)
    fiqOut == (fVec != VecNone));

  assert_vec_pend_R5: assert property (@(posedge clk) disable iff (rst)
    (nVec != VecNone) |-> normPend[nVec[SrcIdxW-1:0]]);

  assert_fvec_pend_R7: assert property (@(posedge clk) disable iff (rst)
    (fVec != VecNone) |-> fastPend[fVec[SrcIdxW-1:0]]);

  assert_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (lvlReg != '1 && nVec != VecNone) |->
      ({1'b0, prioFlat[int'(nVec[SrcIdxW-1:0])*PrioW +: PrioW]} > lvlReg));
endmodule

// File: rtl/vecIntCtl.sv
module vecIntCtl import vecIntPkg::*; (
  input  logic clk,
  input  logic rst,
  input  logic busSel,
  input  logic busWe,
  input  logic [AddrW-1:0] busAddr,
  input  logic [WordW-1:0] busWdata,
  output logic [WordW-1:0] busRdata,
  input  logic [SrcN-1:0] srcIn,
  output logic irqOut,
  output logic fiqOut
);
  strobeT stb;

  vecIntDecode u_decode (
    .busSel(busSel), .busWe(busWe), .busAddr(busAddr), .stb(stb)
  );

  vecIntRegs u_regs (
    .clk(clk), .rst(rst), .stb(stb), .wdata(busWdata), .srcIn(srcIn),
    .rdata(busRdata), .irqOut(irqOut), .fiqOut(fiqOut)
  );
endmodule

// File: tb/vecIntCtl_tb.sv
module vecIntCtl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busSel = 1'b0, busWe = 1'b0;
  logic [6:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] srcIn = '0;
  logic irqOut, fiqOut;

  int nTests = 0;
  int nFail = 0;
  bit rdPend = 1'b0;
  bit done = 1'b0;
  logic [7:0] qAddr[$];
  logic [31:0] qExp[$];
  string qTag[$];

  always #5 clk = ~clk;

  vecIntCtl u_dut (
    .clk(clk), .rst(rst), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcIn(srcIn),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d; rdPend = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    qAddr.push_back({1'b0, a}); qExp.push_back(e); qTag.push_back(t);
    rdPend = 1'b1;
  endtask

  task automatic chkOut(input logic [1:0] e, input string t);
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
    qAddr.push_back(8'hFF); qExp.push_back({30'b0, e}); qTag.push_back(t);
    rdPend = 1'b1;
  endtask

  task automatic setSrc(input logic [63:0] v);
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0; rdPend = 1'b0; srcIn = v;
  endtask

  // monitor: pops expected items and compares with the design
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rdPend && qAddr.size() > 0) begin
        logic [7:0] a;
        logic [31:0] e, act;
        string t;
        a = qAddr.pop_front(); e = qExp.pop_front(); t = qTag.pop_front();
        act = (a == 8'hFF) ? {30'b0, fiqOut, irqOut} : busRdata;
        nTests++;
        if (act !== e) begin
          nFail++;
          $display("FAIL %s addr=%02h actual=%08h expected=%08h", t, a, act, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    rd(7'h00, 32'h0, "R1 ctl");
    rd(7'h04, 32'h1F, "R1 level");
    rd(7'h10, 32'h0, "R1 en hi");
    rd(7'h14, 32'h0, "R1 en lo");
    rd(7'h18, 32'h0, "R1 type hi");
    rd(7'h1C, 32'h0, "R1 type lo");
    rd(7'h54, 32'h0, "R1 force lo");
    rd(7'h20, 32'h0, "R1 prio g7");
    rd(7'h3C, 32'h0, "R1 prio g0");
    rd(7'h40, 32'hFFFF_0000, "R5 idle nvec");
    rd(7'h44, 32'hFFFF_0000, "R7 idle fvec");
    chkOut(2'b00, "R8 idle outputs");
    wr(7'h00, 32'hA5A5_0F0F);
    rd(7'h00, 32'hA5A5_0F0F, "R1 ctl readback");
    wr(7'h00, 32'h0);
    // enable by number
    wr(7'h08, 32'd5);
    wr(7'h08, 32'd40);
    rd(7'h14, 32'h20, "R2 set 5");
    rd(7'h10, 32'h100, "R10 set 40 in high word");
    wr(7'h08, 32'd64);
    rd(7'h14, 32'h20, "R2 ignore 64 lo");
    rd(7'h10, 32'h100, "R2 ignore 64 hi");
    wr(7'h0C, 32'd5);
    rd(7'h14, 32'h0, "R2 clear 5");
    wr(7'h0C, 32'd100);
    rd(7'h10, 32'h100, "R2 ignore clear 100");
    // source 40 raised
    setSrc(64'h1 << 40);
    rd(7'h48, 32'h100, "R10 raw hi");
    rd(7'h4C, 32'h0, "R10 raw lo");
    rd(7'h58, 32'h100, "R4 norm pend hi");
    rd(7'h40, 32'h0028_0000, "R5 single source");
    chkOut(2'b01, "R8 irq only");
    // forced source 3
    wr(7'h08, 32'd3);
    wr(7'h54, 32'h8);
    rd(7'h50, 32'h0, "R10 force hi");
    rd(7'h5C, 32'h8, "R4 forced pend lo");
    rd(7'h40, 32'h0028_0000, "R5 tie higher number");
    wr(7'h3C, 32'h0000_5000);
    rd(7'h40, 32'h0003_0000, "R11 vector after prio write");
    rd(7'h3C, 32'h0000_5000, "R9 group 0 nibble 3");
    wr(7'h28, 32'h7);
    rd(7'h28, 32'h7, "R9 group 5 at 0x28");
    rd(7'h40, 32'h0028_0000, "R5 higher prio wins");
    // mask level
    wr(7'h04, 32'd6);
    rd(7'h40, 32'h0028_0000, "R6 level 6 keeps prio 7");
    wr(7'h04, 32'd7);
    rd(7'h40, 32'hFFFF_0000, "R6 level 7 hides all");
    chkOut(2'b00, "R6 irq hidden");
    rd(7'h5C, 32'h8, "R6 pending unaffected");
    wr(7'h04, 32'h1F);
    rd(7'h40, 32'h0028_0000, "R6 level 1F hides none");
    // fast class
    wr(7'h1C, 32'h8);
    rd(7'h5C, 32'h0, "R3 leaves normal");
    rd(7'h64, 32'h8, "R3 fast pend lo");
    rd(7'h44, 32'h0003_0000, "R7 fast vec 3");
    chkOut(2'b11, "R8 both requests");
    wr(7'h08, 32'd33);
    wr(7'h18, 32'h2);
    setSrc((64'h1 << 40) | (64'h1 << 33));
    rd(7'h60, 32'h2, "R4 fast pend hi");
    rd(7'h44, 32'h0003_0000, "R7 lowest number wins");
    wr(7'h54, 32'h0);
    rd(7'h44, 32'h0021_0000, "R7 after force removed");
    // level behaviour
    setSrc(64'h1 << 33);
    rd(7'h40, 32'hFFFF_0000, "R5 line dropped");
    chkOut(2'b10, "R8 fiq only");
    wr(7'h0C, 32'd33);
    rd(7'h44, 32'hFFFF_0000, "R7 disabled");
    chkOut(2'b00, "R8 none");
    setSrc(64'h0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule